// File: doc/BRIEF.md
# Edge-Interrupt GPIO Register Bank

This block is a bank of general-purpose pins for a card-socket controller. Each pin can be set as an input or an output. The block records rising and falling transitions on its inputs in sticky status registers and raises one interrupt line while any armed transition is still pending. Software sets pin direction, drives output levels, arms either edge on any pin, reads the synchronised input levels and acknowledges events by writing ones to the status bits. In a socket controller, the card-detect inputs are active low, so a high level on either detect pin means the socket is empty. The card-ready pin is armed for falling edges only, and its falling-edge status bit is the card interrupt source.

The host side is a plain synchronous register port with 16-bit registers. The register file is big-endian, so the two bytes of every host halfword are swapped on both writes and reads. The port has no back-pressure: every request presented with `host_valid` is accepted in that cycle. Read data comes back with `host_rvalid` exactly one cycle later, and the host must be able to take it then. Pin inputs are asynchronous and pass through a two-flop synchroniser before edges are detected.

Top module: `edge_irq_gpio_bank`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` and `pin_out` are all 0 (every pin is an input), and `irq` is 0.
- R2: Host data is byte-swapped in both directions. The internal register value is `{host_wdata[7:0], host_wdata[15:8]}`, and a read returns the register value with its two bytes exchanged. Writing 16'h12C4 to output data drives `pin_out` = 16'hC412 and reads back as 16'h12C4.
- R3: Register map: 0 direction, 1 input data, 2 output data, 3 rising enable, 4 falling enable, 5 rising status, 6 falling status. `pin_oe` follows the direction register and `pin_out` follows the output-data register from the cycle after the write.
- R4: The input-data register shows `pin_in` after two synchronising flops. A read accepted in the second clock edge after a pin change still returns the old level, and a read accepted one cycle later returns the new level.
- R5: When its rising enable is set, a 0-to-1 transition of a pin sets its rising-status bit on the third clock edge after the pin changes. The bit then stays set until it is cleared.
- R6: When its falling enable is set, a 1-to-0 transition of a pin sets its falling-status bit with the same timing as R5, and the pin's rising status is not affected.
- R7: A status bit latches only when its enable bit is set. A transition on an unarmed pin, or on the edge a pin is not armed for, leaves both status registers unchanged.
- R8: Writing a status register clears every bit written as 1 and leaves every bit written as 0 unchanged. Several bits can be cleared in one write.
- R9: If a transition would set a status bit in the same cycle that a write clears that bit, the bit ends up set.
- R10: `irq` is high exactly while some pin has (rising status and rising enable) or (falling status and falling enable). Clearing the enable drops `irq` but keeps the status bit.
- R11: Address 7 reads as 0. Writes to address 7 and to the input-data register change no register.
- R12: `host_rvalid` is high in the cycle after a read request and low in the cycle after any other cycle. `host_rdata` holds the data of the most recent read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_valid | input | 1 | Host request in this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Write data, byte-swapped on the bus |
| host_rdata | output | 16 | Read data, byte-swapped on the bus |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| pin_in | input | NPINS | Asynchronous pin input levels |
| pin_out | output | NPINS | Pin output levels |
| pin_oe | output | NPINS | Pin output enables (1 = output) |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bound checker watches, on every cycle, that a status bit only rises where its enable was set, that a status bit only falls in the cycle after a write to its register, that `irq` never fires without pending status, and that direction writes and read responses appear with their fixed one-cycle timing. Only the directed scenarios can show the exact three-edge delay from a pin change to a status bit, the two-flop input readback latency, the byte order of data, the set-over-clear collision and the clearing of several bits at once, because each needs a specific stimulus placed in time and an expected value worked out from it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR     = 3'd0,
    RA_DIN     = 3'd1,
    RA_DOUT    = 3'd2,
    RA_RISE_EN = 3'd3,
    RA_FALL_EN = 3'd4,
    RA_RISE_ST = 3'd5,
    RA_FALL_ST = 3'd6,
    RA_NONE    = 3'd7
  } reg_addr_e;

  localparam int EDGE_RISE = 0;
  localparam int EDGE_FALL = 1;
  localparam int N_EDGES   = 2;

  // Exchange the two bytes of a halfword (big-endian register file).
  function automatic logic [REG_W-1:0] bswap16(input logic [REG_W-1:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] sync_q,
  output logic [NPINS-1:0] rise_hit,
  output logic [NPINS-1:0] fall_hit
);
  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_hit = sync_q & ~prev_q;
  assign fall_hit = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] edge_hit,
  input  logic [NPINS-1:0] arm,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] status
);
  logic [NPINS-1:0] clr_bits;
  logic [NPINS-1:0] set_bits;

  assign clr_bits = clr_we ? clr_mask : '0;
  assign set_bits = edge_hit & arm;

  // A set in the same cycle as a clear takes priority.
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_bits) | set_bits;
  end
endmodule

// File: rtl/gpio_host_regs.sv
module gpio_host_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  input  logic [NPINS-1:0]  sync_in,
  input  logic [NPINS-1:0]  rise_st,
  input  logic [NPINS-1:0]  fall_st,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  rise_en_q,
  output logic [NPINS-1:0]  fall_en_q,
  output logic              rise_clr_we,
  output logic              fall_clr_we,
  output logic [NPINS-1:0]  clr_mask,
  output logic [REG_W-1:0]  host_rdata,
  output logic              host_rvalid
);
  logic [REG_W-1:0] wval;
  logic [REG_W-1:0] rmux;
  logic             wr_req;
  logic             rd_req;
  reg_addr_e        ra;

  assign ra     = reg_addr_e'(host_addr);
  assign wr_req = host_valid && host_write;
  assign rd_req = host_valid && !host_write;
  assign wval   = bswap16(host_wdata);

  assign clr_mask    = wval[NPINS-1:0];
  assign rise_clr_we = wr_req && (ra == RA_RISE_ST);
  assign fall_clr_we = wr_req && (ra == RA_FALL_ST);

  always_comb begin
    case (ra)
      RA_DIR:     rmux = REG_W'(dir_q);
      RA_DIN:     rmux = REG_W'(sync_in);
      RA_DOUT:    rmux = REG_W'(dout_q);
      RA_RISE_EN: rmux = REG_W'(rise_en_q);
      RA_FALL_EN: rmux = REG_W'(fall_en_q);
      RA_RISE_ST: rmux = REG_W'(rise_st);
      RA_FALL_ST: rmux = REG_W'(fall_st);
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q       <= '0;
      dout_q      <= '0;
      rise_en_q   <= '0;
      fall_en_q   <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rd_req;
      if (rd_req) host_rdata <= bswap16(rmux);
      if (wr_req) begin
        case (ra)
          RA_DIR:     dir_q     <= wval[NPINS-1:0];
          RA_DOUT:    dout_q    <= wval[NPINS-1:0];
          RA_RISE_EN: rise_en_q <= wval[NPINS-1:0];
          RA_FALL_EN: fall_en_q <= wval[NPINS-1:0];
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/edge_irq_gpio_bank.sv
module edge_irq_gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_valid,
  input  logic             host_write,
  input  logic [2:0]       host_addr,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  output logic             host_rvalid,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  logic [NPINS-1:0] sync_in;
  logic [NPINS-1:0] rise_en;
  logic [NPINS-1:0] fall_en;
  logic [NPINS-1:0] rise_st;
  logic [NPINS-1:0] fall_st;
  logic [NPINS-1:0] clr_mask;
  logic             rise_clr_we;
  logic             fall_clr_we;

  logic [N_EDGES-1:0][NPINS-1:0] hit_v;
  logic [N_EDGES-1:0][NPINS-1:0] arm_v;
  logic [N_EDGES-1:0][NPINS-1:0] st_v;
  logic [N_EDGES-1:0]            clr_v;

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .sync_q   (sync_in),
    .rise_hit (hit_v[EDGE_RISE]),
    .fall_hit (hit_v[EDGE_FALL])
  );

  gpio_host_regs #(.NPINS(NPINS)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .sync_in     (sync_in),
    .rise_st     (rise_st),
    .fall_st     (fall_st),
    .dir_q       (pin_oe),
    .dout_q      (pin_out),
    .rise_en_q   (rise_en),
    .fall_en_q   (fall_en),
    .rise_clr_we (rise_clr_we),
    .fall_clr_we (fall_clr_we),
    .clr_mask    (clr_mask),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  assign arm_v[EDGE_RISE] = rise_en;
  assign arm_v[EDGE_FALL] = fall_en;
  assign clr_v[EDGE_RISE] = rise_clr_we;
  assign clr_v[EDGE_FALL] = fall_clr_we;
  assign rise_st = st_v[EDGE_RISE];
  assign fall_st = st_v[EDGE_FALL];

  for (genvar g = 0; g < N_EDGES; g++) begin : g_edge
    gpio_edge_status #(.NPINS(NPINS)) u_st (
      .clk      (clk),
      .rst      (rst),
      .edge_hit (hit_v[g]),
      .arm      (arm_v[g]),
      .clr_we   (clr_v[g]),
      .clr_mask (clr_mask),
      .status   (st_v[g])
    );
  end

  assign irq = |((rise_st & rise_en) | (fall_st & fall_en));
endmodule

// File: rtl/edge_irq_gpio_bank_chk.sv
module edge_irq_gpio_bank_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             host_valid,
  input logic             host_write,
  input logic [2:0]       host_addr,
  input logic [15:0]      host_wdata,
  input logic [15:0]      host_rdata,
  input logic             host_rvalid,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] rise_st,
  input logic [NPINS-1:0] fall_st,
  input logic [NPINS-1:0] rise_en,
  input logic [NPINS-1:0] fall_en
);
  logic [15:0] wsw;
  assign wsw = {host_wdata[7:0], host_wdata[15:0+8]};

  // R7: a status bit may only rise where its enable was set.
  p_gate_rise_r7: assert property (@(posedge clk) disable iff (rst)
    ((rise_st & ~$past(rise_st) & ~$past(rise_en)) == '0));
  p_gate_fall_r7: assert property (@(posedge clk) disable iff (rst)
    ((fall_st & ~$past(fall_st) & ~$past(fall_en)) == '0));

  // R8: a status bit only drops after a write to its own register.
  p_sticky_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (|($past(rise_st) & ~rise_st)) |-> $past(host_valid && host_write && host_addr == 3'd5));
  p_sticky_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (|($past(fall_st) & ~fall_st)) |-> $past(host_valid && host_write && host_addr == 3'd6));

  // R10: no interrupt without pending status.
  p_irq_needs_status_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((|rise_st) || (|fall_st)));

  // R3: direction write appears on pin_oe one cycle later.
  p_dir_write_r3: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_write && host_addr == 3'd0) |=> (pin_oe == $past(wsw[NPINS-1:0])));

  // R12: read response timing.
  p_rvalid_after_read_r12: assert property (@(posedge clk) disable iff (rst)
    (host_valid && !host_write) |=> host_rvalid);
  p_rvalid_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !(host_valid && !host_write) |=> !host_rvalid);

  // R11: unmapped address reads zero.
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (host_valid && !host_write && host_addr == 3'd7) |=> (host_rdata == 16'h0000));
endmodule

bind edge_irq_gpio_bank edge_irq_gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_valid  (host_valid),
  .host_write  (host_write),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .host_rvalid (host_rvalid),
  .pin_oe      (pin_oe),
  .irq         (irq),
  .rise_st     (rise_st),
  .fall_st     (fall_st),
  .rise_en     (rise_en),
  .fall_en     (fall_en)
);

// File: tb/sim_edge_irq_gpio_bank.sv
`timescale 1ns/1ps
module sim_edge_irq_gpio_bank;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_valid = 1'b0;
  logic          host_write = 1'b0;
  logic [2:0]    host_addr = '0;
  logic [15:0]   host_wdata = '0;
  logic [15:0]   host_rdata;
  logic          host_rvalid;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  edge_irq_gpio_bank #(.NPINS(NP)) u0 (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [15:0] sw(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    @(negedge clk);
    host_valid = 1'b0;
    d = host_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 pin_oe", 16'(pin_oe), 16'h0);
    check("R1 pin_out", 16'(pin_out), 16'h0);
    check("R1 irq", 16'(irq), 16'h0);
    for (int a = 0; a < 7; a++) begin
      bus_read(3'(a), d);
      check("R1 register", d, 16'h0);
    end
  endtask

  task automatic t_swap;
    logic [15:0] d;
    bus_write(3'd2, 16'h12C4);
    check("R2 pin_out swapped", 16'(pin_out), 16'hC412);
    bus_read(3'd2, d);
    check("R2 readback", d, 16'h12C4);
    bus_write(3'd0, 16'h00F0);
    check("R3 pin_oe from direction", 16'(pin_oe), 16'hF000);
    bus_read(3'd0, d);
    check("R3 direction readback", d, 16'h00F0);
  endtask

  task automatic t_din;
    logic [15:0] d;
    pin_in = 16'h3C81;
    settle(1);
    bus_read(3'd1, d);
    check("R4 input not yet visible", d, 16'h0000);
    bus_read(3'd1, d);
    check("R4 synchronised input", d, sw(16'h3C81));
    pin_in = '0;
    settle(4);
  endtask

  task automatic t_latency;
    logic [15:0] d;
    bus_read(3'd0, d);
    check("R12 rvalid after read", 16'(host_rvalid), 16'h1);
    settle(1);
    check("R12 rvalid drops", 16'(host_rvalid), 16'h0);
  endtask

  task automatic t_rise;
    logic [15:0] d;
    bus_write(3'd3, sw(16'h0058));       // arm rising on pins 3,4,6
    pin_in[3] = 1'b1;
    settle(2);
    check("R5 status not before third edge", 16'(irq), 16'h0);
    settle(1);
    check("R5 irq on third edge", 16'(irq), 16'h1);
    settle(5);
    bus_read(3'd5, d);
    check("R5 rising status sticky", d, sw(16'h0008));
    bus_read(3'd6, d);
    check("R6 falling status untouched", d, 16'h0);
  endtask

  task automatic t_fall;
    logic [15:0] d;
    bus_write(3'd4, sw(16'h0200));       // arm falling on pin 9
    pin_in[9] = 1'b1;
    settle(4);
    bus_read(3'd5, d);
    check("R7 rise on unarmed-rise pin ignored", d, sw(16'h0008));
    pin_in[9] = 1'b0;
    settle(3);
    bus_read(3'd6, d);
    check("R6 falling status set", d, sw(16'h0200));
  endtask

  task automatic t_gate;
    logic [15:0] d;
    pin_in[5] = 1'b1; settle(4);
    pin_in[5] = 1'b0; settle(4);
    bus_read(3'd5, d);
    check("R7 unarmed pin rise status", d, sw(16'h0008));
    bus_read(3'd6, d);
    check("R7 unarmed pin fall status", d, sw(16'h0200));
  endtask

  task automatic t_w1c;
    logic [15:0] d;
    pin_in[4] = 1'b1; pin_in[6] = 1'b1;
    settle(4);
    bus_read(3'd5, d);
    check("R5 three rising bits", d, sw(16'h0058));
    bus_write(3'd5, 16'h0000);
    bus_read(3'd5, d);
    check("R8 zero write keeps bits", d, sw(16'h0058));
    bus_write(3'd5, sw(16'h0008));
    bus_read(3'd5, d);
    check("R8 single clear", d, sw(16'h0050));
    bus_write(3'd5, sw(16'h0050));
    bus_read(3'd5, d);
    check("R8 multi clear", d, 16'h0000);
    check("R10 irq from falling status", 16'(irq), 16'h1);
    bus_write(3'd4, 16'h0000);
    check("R10 irq drops with enable", 16'(irq), 16'h0);
    bus_read(3'd6, d);
    check("R10 status kept after disable", d, sw(16'h0200));
    bus_write(3'd6, sw(16'h0200));
    bus_read(3'd6, d);
    check("R8 falling clear", d, 16'h0000);
  endtask

  task automatic t_set_wins;
    logic [15:0] d;
    pin_in[3] = 1'b0;
    settle(4);
    pin_in[3] = 1'b1;
    settle(2);
    bus_write(3'd5, sw(16'h0008));       // clear lands with the set
    bus_read(3'd5, d);
    check("R9 set beats clear", d, sw(16'h0008));
    bus_write(3'd5, sw(16'h0008));
    bus_read(3'd5, d);
    check("R9 later clear works", d, 16'h0000);
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    bus_write(3'd7, 16'hFFFF);
    bus_write(3'd1, 16'hFFFF);
    check("R11 pin_out unchanged", 16'(pin_out), 16'hC412);
    check("R11 pin_oe unchanged", 16'(pin_oe), 16'hF000);
    bus_read(3'd7, d);
    check("R11 address 7 reads zero", d, 16'h0000);
    bus_read(3'd3, d);
    check("R11 rising enable unchanged", d, sw(16'h0058));
  endtask

  initial begin
    settle(4);
    rst = 1'b0;
    settle(1);
    t_reset();
    t_swap();
    t_din();
    t_latency();
    t_rise();
    t_fall();
    t_gate();
    t_w1c();
    t_set_wins();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule